// File: doc/BRIEF.md
# Interrupt Pin Service Unit

This block keeps the per-pin request state of an interrupt router. For each pin it holds a request bit, a delivered flag for edge-mode pins and a remote-pending flag for level-mode pins. It reads the routing entry fields for every pin from its ports: mask, trigger mode, vector and destination. From these it raises a delivery request that carries the selected pin's vector, destination and trigger mode. The request waits on an accept handshake. Destination matching and acceptance on the processor side are outside the block.

End-of-interrupt notices arrive by vector. A level-mode notice clears the remote-pending flag of every level pin whose entry uses that vector. It then delivers the pin again if the pin is still asserted and unmasked. A directed notice does not clear the flag. A per-pin counter tracks back-to-back redeliveries. When a pin reaches the storm limit, its redelivery is held back by a shared delay timer. When the timer expires, all eligible level pins are serviced. A configuration write to a level pin with a pending request triggers a service attempt. Competing requests are offered one at a time, lowest pin first.

Top module: `irq_pin_service`

## Requirements
- R1: A `line_lo_i` pulse on a pin clears its request bit and never causes a delivery; when a pin sees both pulses in the same cycle, the low pulse wins.
- R2: A `line_hi_i` pulse on an edge pin (`cfg_level_i` bit = 0) sets its request bit. It schedules a delivery only if the request bit was clear before; otherwise it is absorbed. In both cases it clears the pin's delivered flag.
- R3: A `line_hi_i` pulse on a level pin (`cfg_level_i` bit = 1) sets its request bit but schedules no delivery while the pin's remote-pending flag is set.
- R4: A pin whose `cfg_mask_i` bit is 1 is never offered on `req_valid_o`, and a pending service for it is dropped.
- R5: An accepted request (`req_valid_o` and `req_ack_i` at a clock edge) sets the delivered flag of an edge pin or the remote-pending flag of a level pin.
- R6: A non-directed level-mode end-of-interrupt with vector V clears the remote-pending flag of every level pin whose vector is V. It redelivers each such pin that is unmasked and still has its request bit set.
- R7: Each redelivery under R6 increments the pin's storm counter. The counter is zeroed when such a notice finds the pin masked or not requesting. When a notice would bring the counter to STORM_LIMIT, the counter is zeroed instead, no immediate delivery happens, and the delay timer starts (if it is idle).
- R8: DEFER_CYCLES cycles after it starts, the timer services every unmasked level pin that has its request bit set and its remote-pending flag clear.
- R9: A notice with `eoi_directed_i` = 1 leaves every remote-pending flag unchanged.
- R10: A `cfg_wr_i` pulse naming a level pin whose request bit is set schedules a service attempt for that pin.
- R11: With several services pending, the lowest unmasked pin number is offered first. It stays offered until accepted, and one pin is served per accept.
- R12: After reset all request bits, flags and counters are zero, the timer is idle and `req_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_hi_i | input | NUM_PINS | Per-pin assertion pulse |
| line_lo_i | input | NUM_PINS | Per-pin deassertion pulse |
| cfg_mask_i | input | NUM_PINS | Entry mask, 1 = masked |
| cfg_level_i | input | NUM_PINS | Trigger mode, 1 = level, 0 = edge |
| cfg_vector_i | input | NUM_PINS*VEC_W | Entry vectors, pin p at bits p*VEC_W |
| cfg_dest_i | input | NUM_PINS*DEST_W | Entry destinations, pin p at bits p*DEST_W |
| cfg_wr_i | input | 1 | Entry write notification |
| cfg_wr_pin_i | input | PIN_W | Pin whose entry was written |
| eoi_valid_i | input | 1 | End-of-interrupt notice strobe |
| eoi_vector_i | input | VEC_W | Vector of the notice |
| eoi_level_i | input | 1 | Notice is for a level-mode interrupt |
| eoi_directed_i | input | 1 | Notice is directed (broadcast suppressed) |
| req_valid_o | output | 1 | Delivery request valid |
| req_pin_o | output | PIN_W | Pin being delivered |
| req_vector_o | output | VEC_W | Vector of the delivered entry |
| req_dest_o | output | DEST_W | Destination of the delivered entry |
| req_level_o | output | 1 | Trigger mode of the delivered entry |
| req_ack_i | input | 1 | Delivery accepted |
| irr_o | output | NUM_PINS | Request bits |
| remote_irr_o | output | NUM_PINS | Remote-pending flags |
| delivered_o | output | NUM_PINS | Edge delivered flags |

## Verification
The hardest state to reach is the storm deferral. The storm counter is only visible through its effect. Reaching the limit needs one level pin held asserted through an unbroken run of vector-matched notices, each of which must be accepted before the next. The stimulus asserts a level pin and accepts its delivery. It then issues notices one at a time while the scoreboard accepts each redelivery. On the notice that reaches the limit, the bench checks that the redelivery is missing and the remote-pending flag is clear. It then checks that the delivery appears only after the shortened delay has run out.

// File: rtl/irq_pin_service_pkg.sv
package irq_pin_service_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/irq_pin_slice.sv
module irq_pin_slice
  import irq_pin_service_pkg::*;
#(
  parameter int STORM_LIMIT = 10000,
  localparam int CW = $clog2(STORM_LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_hi_i,
  input  logic line_lo_i,
  input  logic mask_i,
  input  logic level_i,
  input  logic eoi_hit_i,
  input  logic eoi_clr_i,
  input  logic cfg_wr_i,
  input  logic defer_fire_i,
  input  logic ack_i,
  output logic irr_o,
  output logic remote_irr_o,
  output logic delivered_o,
  output logic svc_o,
  output logic storm_o
);
  trig_e trig;
  assign trig = trig_e'(level_i);

  logic          irr_q, irr_d, rirr_q, rirr_d, dlv_q, dlv_d, svc_q, svc_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          svc_set, eoi_act;

  assign eoi_act = eoi_hit_i && eoi_clr_i && (trig == TRIG_LEVEL);

  always_comb begin
    irr_d   = irr_q;
    rirr_d  = rirr_q;
    dlv_d   = dlv_q;
    cnt_d   = cnt_q;
    svc_set = 1'b0;
    storm_o = 1'b0;
    if (line_lo_i) begin
      irr_d = 1'b0;
    end else if (line_hi_i) begin
      irr_d = 1'b1;
      if (trig == TRIG_EDGE) begin
        if (!irr_q) svc_set = 1'b1;
      end else if (!rirr_q) begin
        svc_set = 1'b1;
      end
    end
    if (eoi_act) begin
      rirr_d = 1'b0;
      if (!mask_i && irr_q) begin
        if (cnt_q == CW'(STORM_LIMIT - 1)) begin
          cnt_d   = '0;
          storm_o = 1'b1;
        end else begin
          cnt_d   = cnt_q + 1'b1;
          svc_set = 1'b1;
        end
      end else begin
        cnt_d = '0;
      end
    end
    if (defer_fire_i && trig == TRIG_LEVEL && irr_q && !rirr_q) svc_set = 1'b1;
    if (cfg_wr_i && trig == TRIG_LEVEL && irr_q) svc_set = 1'b1;
    if (ack_i) begin
      if (trig == TRIG_LEVEL) rirr_d = 1'b1;
      else                    dlv_d  = 1'b1;
    end
    if (line_hi_i && !line_lo_i && trig == TRIG_EDGE) dlv_d = 1'b0;
    svc_d = ((svc_q && !ack_i) || svc_set) && !mask_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q  <= 1'b0;
      rirr_q <= 1'b0;
      dlv_q  <= 1'b0;
      svc_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      irr_q  <= irr_d;
      rirr_q <= rirr_d;
      dlv_q  <= dlv_d;
      svc_q  <= svc_d;
      cnt_q  <= cnt_d;
    end
  end

  assign irr_o        = irr_q;
  assign remote_irr_o = rirr_q;
  assign delivered_o  = dlv_q;
  assign svc_o        = svc_q && !mask_i;
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int NUM_PINS = 8,
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic [NUM_PINS-1:0] req_i,
  output logic                valid_o,
  output logic [PIN_W-1:0]    idx_o,
  output logic [NUM_PINS-1:0] grant_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = PIN_W'(i);
    end
  end
  assign valid_o = |req_i;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_grant
    assign grant_o[g] = valid_o && (idx_o == PIN_W'(g));
  end
endmodule

// File: rtl/irq_defer_timer.sv
module irq_defer_timer #(
  parameter int DEFER_CYCLES = 500000,
  localparam int TW = $clog2(DEFER_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic fire_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (cnt_q != '0)             cnt_q <= cnt_q - 1'b1;
    else if (start_i)                 cnt_q <= TW'(DEFER_CYCLES);
  end

  assign fire_o = (cnt_q == TW'(1));
endmodule

// File: rtl/irq_pin_service.sv
module irq_pin_service
  import irq_pin_service_pkg::*;
#(
  parameter int NUM_PINS     = 8,
  parameter int VEC_W        = 8,
  parameter int DEST_W       = 8,
  parameter int STORM_LIMIT  = 10000,
  parameter int CLK_HZ       = 50000000,
  parameter int DEFER_CYCLES = CLK_HZ / 100,
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_PINS-1:0]        line_hi_i,
  input  logic [NUM_PINS-1:0]        line_lo_i,
  input  logic [NUM_PINS-1:0]        cfg_mask_i,
  input  logic [NUM_PINS-1:0]        cfg_level_i,
  input  logic [NUM_PINS*VEC_W-1:0]  cfg_vector_i,
  input  logic [NUM_PINS*DEST_W-1:0] cfg_dest_i,
  input  logic                       cfg_wr_i,
  input  logic [PIN_W-1:0]           cfg_wr_pin_i,
  input  logic                       eoi_valid_i,
  input  logic [VEC_W-1:0]           eoi_vector_i,
  input  logic                       eoi_level_i,
  input  logic                       eoi_directed_i,
  output logic                       req_valid_o,
  output logic [PIN_W-1:0]           req_pin_o,
  output logic [VEC_W-1:0]           req_vector_o,
  output logic [DEST_W-1:0]          req_dest_o,
  output logic                       req_level_o,
  input  logic                       req_ack_i,
  output logic [NUM_PINS-1:0]        irr_o,
  output logic [NUM_PINS-1:0]        remote_irr_o,
  output logic [NUM_PINS-1:0]        delivered_o
);
  logic [NUM_PINS-1:0] svc, storm, grant;
  logic                defer_fire, eoi_clr;

  assign eoi_clr = eoi_level_i && !eoi_directed_i;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic eoi_hit, wr_hit;
    assign eoi_hit = eoi_valid_i && (cfg_vector_i[p*VEC_W +: VEC_W] == eoi_vector_i);
    assign wr_hit  = cfg_wr_i && (cfg_wr_pin_i == PIN_W'(p));

    irq_pin_slice #(.STORM_LIMIT(STORM_LIMIT)) u_slice (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .line_hi_i    (line_hi_i[p]),
      .line_lo_i    (line_lo_i[p]),
      .mask_i       (cfg_mask_i[p]),
      .level_i      (cfg_level_i[p]),
      .eoi_hit_i    (eoi_hit),
      .eoi_clr_i    (eoi_clr),
      .cfg_wr_i     (wr_hit),
      .defer_fire_i (defer_fire),
      .ack_i        (grant[p] && req_ack_i),
      .irr_o        (irr_o[p]),
      .remote_irr_o (remote_irr_o[p]),
      .delivered_o  (delivered_o[p]),
      .svc_o        (svc[p]),
      .storm_o      (storm[p])
    );
  end

  irq_lowest_pick #(.NUM_PINS(NUM_PINS)) u_pick (
    .req_i   (svc),
    .valid_o (req_valid_o),
    .idx_o   (req_pin_o),
    .grant_o (grant)
  );

  irq_defer_timer #(.DEFER_CYCLES(DEFER_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (|storm),
    .fire_o  (defer_fire)
  );

  always_comb begin
    req_vector_o = '0;
    req_dest_o   = '0;
    req_level_o  = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (grant[i]) begin
        req_vector_o = cfg_vector_i[i*VEC_W +: VEC_W];
        req_dest_o   = cfg_dest_i[i*DEST_W +: DEST_W];
        req_level_o  = cfg_level_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_pin_service_chk.sv
module irq_pin_service_chk #(
  parameter int NUM_PINS = 8,
  parameter int PIN_W    = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_PINS-1:0] line_hi_i,
  input logic [NUM_PINS-1:0] line_lo_i,
  input logic [NUM_PINS-1:0] cfg_mask_i,
  input logic [NUM_PINS-1:0] cfg_level_i,
  input logic                eoi_valid_i,
  input logic                eoi_directed_i,
  input logic                req_valid_o,
  input logic [PIN_W-1:0]    req_pin_o,
  input logic                req_ack_i,
  input logic [NUM_PINS-1:0] irr_o,
  input logic [NUM_PINS-1:0] remote_irr_o,
  input logic [NUM_PINS-1:0] delivered_o
);
  AST_LO_CLEARS_IRR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_lo_i != '0) |=> ((irr_o & $past(line_lo_i)) == '0)); // R1

  AST_MASKED_NOT_OFFERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !cfg_mask_i[req_pin_o]); // R4

  AST_LEVEL_ACK_SETS_RIRR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ack_i && cfg_level_i[req_pin_o])
      |=> remote_irr_o[$past(req_pin_o)]); // R5

  AST_EDGE_ACK_SETS_DLV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ack_i && !cfg_level_i[req_pin_o] && !line_hi_i[req_pin_o])
      |=> delivered_o[$past(req_pin_o)]); // R5

  AST_DIRECTED_KEEPS_RIRR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_valid_i && eoi_directed_i) |=> (($past(remote_irr_o) & ~remote_irr_o) == '0)); // R9

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ack_i && !cfg_mask_i[req_pin_o]) |=> req_valid_o); // R11
endmodule

bind irq_pin_service irq_pin_service_chk #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_chk (.*);

// File: tb/irq_pin_service_test.sv
module irq_pin_service_test;
  localparam int N = 4, VW = 8, DW = 4, PW = 2;
  localparam int LIMIT = 3, DEFER = 20;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic [N-1:0] line_hi = '0, line_lo = '0, mask = '0, level = '0;
  logic [N*VW-1:0] vec;
  logic [N*DW-1:0] dst;
  logic cfg_wr = 0, eoi_v = 0, eoi_lvl = 0, eoi_dir = 0, ack = 0;
  logic [PW-1:0] wr_pin = '0;
  logic [VW-1:0] eoi_vec = '0;
  logic req_valid, req_level;
  logic [PW-1:0] req_pin;
  logic [VW-1:0] req_vec;
  logic [DW-1:0] req_dst;
  logic [N-1:0] irr, rirr, dlv;

  for (genvar g = 0; g < N; g++) begin : g_cfg
    assign vec[g*VW +: VW] = VW'(8'h30 + g);
    assign dst[g*DW +: DW] = DW'(g + 1);
  end

  irq_pin_service #(.NUM_PINS(N), .VEC_W(VW), .DEST_W(DW), .STORM_LIMIT(LIMIT),
                    .DEFER_CYCLES(DEFER)) uut (
    .clk_i(clk), .rst_ni(rst_n), .line_hi_i(line_hi), .line_lo_i(line_lo),
    .cfg_mask_i(mask), .cfg_level_i(level), .cfg_vector_i(vec), .cfg_dest_i(dst),
    .cfg_wr_i(cfg_wr), .cfg_wr_pin_i(wr_pin), .eoi_valid_i(eoi_v),
    .eoi_vector_i(eoi_vec), .eoi_level_i(eoi_lvl), .eoi_directed_i(eoi_dir),
    .req_valid_o(req_valid), .req_pin_o(req_pin), .req_vector_o(req_vec),
    .req_dest_o(req_dst), .req_level_o(req_level), .req_ack_i(ack),
    .irr_o(irr), .remote_irr_o(rirr), .delivered_o(dlv));

  int checks = 0, fails = 0;
  bit ack_en = 1, done = 0;
  int exp_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: accept and compare each delivery against the scoreboard
  always @(negedge clk) begin
    ack <= 1'b0;
    if (rst_n && ack_en && req_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R1-R10 unexpected delivery actual=pin%0d expected=none", req_pin);
      end else begin
        int p;
        p = exp_q.pop_front();
        if (req_pin !== PW'(p) || req_vec !== VW'(8'h30 + p) || req_dst !== DW'(p + 1)
            || req_level !== level[p]) begin
          fails++;
          $display("FAIL R11 delivery actual=pin%0d/%0h expected=pin%0d/%0h",
                   req_pin, req_vec, p, 8'h30 + p);
        end
      end
      ack <= 1'b1;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic hi(logic [N-1:0] m);
    @(negedge clk); line_hi = m; @(negedge clk); line_hi = '0;
  endtask
  task automatic lo(logic [N-1:0] m);
    @(negedge clk); line_lo = m; @(negedge clk); line_lo = '0;
  endtask
  task automatic eoi(int p, bit dir);
    @(negedge clk); eoi_v = 1; eoi_vec = VW'(8'h30 + p); eoi_lvl = 1; eoi_dir = dir;
    @(negedge clk); eoi_v = 0; eoi_dir = 0;
  endtask

  initial begin
    level = 4'b1010;
    mask  = 4'b1100;
    idle(2);
    chk("R12 irr", irr, 0); chk("R12 rirr", rirr, 0);
    chk("R12 dlv", dlv, 0); chk("R12 valid", req_valid, 0);
    rst_n = 1;
    idle(2);
    // edge pin 0
    exp_q.push_back(0); hi(4'b0001); idle(3);
    chk("R5 delivered pin0", dlv[0], 1); chk("R2 irr pin0", irr[0], 1);
    hi(4'b0001); idle(3);                       // absorbed
    chk("R2 absorbed, dlv cleared", dlv[0], 0);
    lo(4'b0001); idle(2);
    chk("R1 irr cleared", irr[0], 0);
    exp_q.push_back(0); hi(4'b0001); idle(3);
    // level pin 1
    exp_q.push_back(1); hi(4'b0010); idle(3);
    chk("R5 rirr pin1", rirr[1], 1);
    hi(4'b0010); idle(3);                       // R3 blocked
    chk("R3 no delivery, queue", exp_q.size(), 0);
    // masked edge pin 2
    hi(4'b0100); idle(3);
    chk("R4 masked irr", irr[2], 1);
    // EOI redelivery
    exp_q.push_back(1); eoi(1, 0); idle(3);
    chk("R6 rirr after redelivery", rirr[1], 1);
    eoi(1, 1); idle(3);
    chk("R9 directed keeps rirr", rirr[1], 1);
    lo(4'b0010); eoi(1, 0); idle(3);
    chk("R6 rirr cleared, no redelivery", rirr[1], 0);
    // storm
    exp_q.push_back(1); hi(4'b0010); idle(3);
    exp_q.push_back(1); eoi(1, 0); idle(3);
    exp_q.push_back(1); eoi(1, 0); idle(3);
    exp_q.push_back(1); eoi(1, 0); idle(5);
    chk("R7 deferred, still expected", exp_q.size(), 1);
    chk("R7 rirr clear while deferred", rirr[1], 0);
    idle(DEFER + 5);
    chk("R8 deferred delivery done", exp_q.size(), 0);
    chk("R8 rirr set", rirr[1], 1);
    // config write on level pin 3
    hi(4'b1000); idle(3);
    chk("R4 masked level pin3 irr", irr[3], 1);
    @(negedge clk); mask[3] = 0;
    idle(2);
    chk("R10 no service before write", exp_q.size(), 0);
    exp_q.push_back(3);
    @(negedge clk); cfg_wr = 1; wr_pin = 2'd3; @(negedge clk); cfg_wr = 0;
    idle(3);
    chk("R10 write serviced", rirr[3], 1);
    // arbitration
    ack_en = 0;
    @(negedge clk); mask[2] = 0;
    lo(4'b0101);
    exp_q.push_back(0); exp_q.push_back(2);
    hi(4'b0101); idle(3);
    chk("R11 valid held", req_valid, 1);
    chk("R11 lowest first", req_pin, 0);
    ack_en = 1; idle(5);
    chk("R11 both served", exp_q.size(), 0);
    chk("R5 dlv pins 0,2", dlv & 4'b0101, 4'b0101);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule